// File: doc/BRIEF.md
# CBR Virtual Circuit List Scheduler

This block generates constant-bit-rate cell transmit requests. It steps through a programmable list of virtual-circuit (VC) identifiers and emits one request each time an external pacing clock falls. The pacing clock runs asynchronously to the system clock. It is resynchronised inside the block, and it carries two kinds of information on the same wire. Each falling edge paces one cell. A high phase lasting long enough marks a frame boundary and returns the list walk to its first entry.

Downstream cell processing works on one request at a time and signals completion with a one-cycle done pulse. A pacing edge that arrives while a request is still being processed is held as a single pending request, which issues as soon as the done pulse appears. Software-side logic fills the list through a simple write port and programs how many entries the walk covers.

Top module: `cbr_list_sched`

## Requirements
- R1: Each falling edge of `pace_clk_i` produces exactly one `sched_stb_o` pulse, one cycle wide, when nothing is in flight. The pulse appears on the third rising edge of `clk_i` after the pacing clock goes low: two synchroniser stages, then the output register.
- R2: After a strobe, no further strobe is issued until `cell_done_i` has been high for one cycle. A request waiting on done issues on the clock edge where done is seen.
- R3: Each issue advances the list pointer by one. After entry `list_len_i`-1 the pointer wraps to entry 0. A length of 0 or 1 always selects entry 0 once the pointer is at 0.
- R4: If the synchronised pacing clock is high for 8 consecutive system-clock samples, the pointer returns to entry 0, so the next issue uses entry 0. A high phase of 7 samples leaves the pointer unchanged.
- R5: If the pointer is rewound while a request is pending, that request issues entry 0.
- R6: At most one request is held pending. Falling edges that arrive while a request is already pending are dropped.
- R7: When `wr_en_i` is high, `wr_vc_i` is written into entry `wr_idx_i`. The next issue of that entry presents the new value on `sched_vc_o`.
- R8: Reset clears the strobe, the output VC (to 0), the pointer (to entry 0), the pending request and the in-flight state.
- R9: A high phase longer than 8 samples still yields exactly one strobe, for the falling edge that ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pace_clk_i | input | 1 | Asynchronous pacing clock; falls pace cells, long highs rewind |
| cell_done_i | input | 1 | One-cycle pulse: the in-flight request has been processed |
| list_len_i | input | $clog2(LIST_DEPTH+1) | Number of list entries walked before wrapping |
| wr_en_i | input | 1 | List write enable |
| wr_idx_i | input | $clog2(LIST_DEPTH) | List entry to write |
| wr_vc_i | input | VC_W | VC identifier to store |
| sched_stb_o | output | 1 | One-cycle transmit request |
| sched_vc_o | output | VC_W | VC identifier for the request |

## Verification
The bench measures the edge-to-strobe latency. A synchroniser that is one stage short or long shifts the strobe by a cycle and fails that check.

High phases of exactly 7 and exactly 8 cycles test the rewind threshold. A counter that is off by one either rewinds on the shorter phase or misses the longer one. A 10-cycle high phase shows whether a saturating counter fires its rewind more than once or emits extra strobes.

With done withheld, the bench sends two extra edges. A design that queued edges instead of dropping them would emit a second late strobe. A rewind that happens during a pending request must make that request use entry 0, and a design that latched the index early would issue a stale entry.

Wrap at a programmed length and list lengths of 1 are also exercised.

// File: rtl/cbr_sched_pkg.sv
package cbr_sched_pkg;

    localparam int unsigned CBR_SYNC_DEFAULT   = 2;
    localparam int unsigned CBR_REWIND_DEFAULT = 8;

    // Events derived from the pacing clock, one cycle each
    typedef struct packed {
        logic fall;    // synchronised falling edge
        logic rewind;  // high phase reached the rewind threshold
    } pace_evt_t;

endpackage

// File: rtl/cbr_pace_detect.sv
module cbr_pace_detect
    import cbr_sched_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = CBR_SYNC_DEFAULT,
    parameter int unsigned REWIND_CNT  = CBR_REWIND_DEFAULT
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      pace_i,
    output pace_evt_t evt_o
);

    localparam int unsigned CNT_W = $clog2(REWIND_CNT + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [CNT_W-1:0]       hcnt;
    } pd_state_t;

    pd_state_t st_d, st_q;
    logic [SYNC_STAGES-1:0] sync_nxt;
    logic lvl;

    assign sync_nxt[0] = pace_i;
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        assign sync_nxt[g] = st_q.sync[g-1];
    end

    assign lvl = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = sync_nxt;
        st_d.prev = lvl;
        if (lvl) begin
            if (st_q.hcnt != CNT_W'(REWIND_CNT))
                st_d.hcnt = st_q.hcnt + CNT_W'(1);
        end else begin
            st_d.hcnt = '0;
        end
        evt_o.fall   = st_q.prev & ~lvl;
        evt_o.rewind = lvl && (st_q.hcnt == CNT_W'(REWIND_CNT - 1));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_o.fall |=> !evt_o.fall); // R1
    AST_REWIND_ONCE: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_o.rewind |=> !evt_o.rewind); // R9

endmodule

// File: rtl/cbr_vc_list.sv
module cbr_vc_list #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned VC_W  = 16,
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [VC_W-1:0]  wr_vc_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [VC_W-1:0]  rd_vc_o
);

    logic [VC_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (wr_en_i) mem_q[wr_idx_i] <= wr_vc_i;
    end

    assign rd_vc_o = mem_q[rd_idx_i];

endmodule

// File: rtl/cbr_issue_ctrl.sv
module cbr_issue_ctrl
    import cbr_sched_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned LEN_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  pace_evt_t        evt_i,
    input  logic             done_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             issue_o,
    output logic [IDX_W-1:0] sel_idx_o
);

    localparam int unsigned CMP_W = (IDX_W + 1 > LEN_W) ? IDX_W + 1 : LEN_W;

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
        logic             pend;
        logic             busy;
    } ic_state_t;

    ic_state_t st_d, st_q;
    logic req, ready;
    logic [IDX_W-1:0] base;
    logic [CMP_W-1:0] nxt;

    always_comb begin
        st_d  = st_q;
        req   = evt_i.fall | st_q.pend;
        ready = ~st_q.busy | done_i;
        base  = evt_i.rewind ? '0 : st_q.ptr;
        nxt   = CMP_W'(base) + CMP_W'(1);
        issue_o   = req & ready;
        sel_idx_o = base;
        st_d.ptr  = base;
        if (issue_o) begin
            st_d.ptr  = (nxt >= CMP_W'(len_i)) ? '0 : IDX_W'(nxt);
            st_d.busy = 1'b1;
            st_d.pend = 1'b0;
        end else begin
            if (done_i) st_d.busy = 1'b0;
            if (req)    st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    AST_PEND_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.pend |-> st_q.busy); // R6
    AST_REWIND_TO_TOP: assert property (@(posedge clk_i) disable iff (rst_i)
        (evt_i.rewind && !issue_o) |=> (st_q.ptr == '0)); // R4

endmodule

// File: rtl/cbr_list_sched.sv
module cbr_list_sched
    import cbr_sched_pkg::*;
#(
    parameter int unsigned LIST_DEPTH  = 256,
    parameter int unsigned VC_W        = 16,
    parameter int unsigned SYNC_STAGES = CBR_SYNC_DEFAULT,
    parameter int unsigned REWIND_CNT  = CBR_REWIND_DEFAULT
) (
    input  logic                              clk_i,
    input  logic                              rst_i,
    input  logic                              pace_clk_i,
    input  logic                              cell_done_i,
    input  logic [$clog2(LIST_DEPTH+1)-1:0]   list_len_i,
    input  logic                              wr_en_i,
    input  logic [$clog2(LIST_DEPTH)-1:0]     wr_idx_i,
    input  logic [VC_W-1:0]                   wr_vc_i,
    output logic                              sched_stb_o,
    output logic [VC_W-1:0]                   sched_vc_o
);

    localparam int unsigned IDX_W = $clog2(LIST_DEPTH);
    localparam int unsigned LEN_W = $clog2(LIST_DEPTH + 1);

    typedef struct packed {
        logic            stb;
        logic [VC_W-1:0] vc;
    } out_state_t;

    out_state_t o_d, o_q;
    pace_evt_t  evt;
    logic       issue;
    logic [IDX_W-1:0] sel_idx;
    logic [VC_W-1:0]  rd_vc;

    cbr_pace_detect #(
        .SYNC_STAGES (SYNC_STAGES),
        .REWIND_CNT  (REWIND_CNT)
    ) u_pace (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pace_i (pace_clk_i),
        .evt_o  (evt)
    );

    cbr_issue_ctrl #(
        .IDX_W (IDX_W),
        .LEN_W (LEN_W)
    ) u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .evt_i     (evt),
        .done_i    (cell_done_i),
        .len_i     (list_len_i),
        .issue_o   (issue),
        .sel_idx_o (sel_idx)
    );

    cbr_vc_list #(
        .DEPTH (LIST_DEPTH),
        .VC_W  (VC_W),
        .IDX_W (IDX_W)
    ) u_list (
        .clk_i    (clk_i),
        .wr_en_i  (wr_en_i),
        .wr_idx_i (wr_idx_i),
        .wr_vc_i  (wr_vc_i),
        .rd_idx_i (sel_idx),
        .rd_vc_o  (rd_vc)
    );

    always_comb begin
        o_d     = o_q;
        o_d.stb = issue;
        if (issue) o_d.vc = rd_vc;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) o_q <= '0;
        else       o_q <= o_d;
    end

    assign sched_stb_o = o_q.stb;
    assign sched_vc_o  = o_q.vc;

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (rst_i)
        (sched_stb_o && !cell_done_i) |=> !sched_stb_o); // R2
    AST_STB_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sched_stb_o) |-> $past(issue)); // R1

endmodule

// File: tb/sim_cbr_list_sched.sv
module sim_cbr_list_sched;

    localparam int unsigned DEPTH = 256;
    localparam int unsigned VW    = 16;
    localparam int unsigned NVEC  = 12;
    // {high cycles, low cycles, expected entry}
    localparam int unsigned VEC [NVEC][3] = '{
        '{3, 4, 0}, '{3, 4, 1}, '{3, 4, 2}, '{3, 4, 3}, '{3, 4, 4}, '{3, 4, 0},
        '{3, 4, 1}, '{10, 4, 0}, '{3, 4, 1}, '{7, 4, 2}, '{8, 4, 0}, '{3, 4, 1}
    };

    logic clk = 1'b0;
    logic rst, pace, done, wr_en;
    logic [$clog2(DEPTH+1)-1:0] len;
    logic [$clog2(DEPTH)-1:0]   wr_idx;
    logic [VW-1:0] wr_vc;
    logic stb;
    logic [VW-1:0] vc;

    int n_chk = 0, n_fail = 0;
    int stb_cnt, stb_pos, step_idx;
    logic [VW-1:0] last_vc;
    bit auto_done = 1'b1;

    always #2 clk = ~clk;

    cbr_list_sched #(.LIST_DEPTH(DEPTH), .VC_W(VW)) u0 (
        .clk_i(clk), .rst_i(rst), .pace_clk_i(pace), .cell_done_i(done),
        .list_len_i(len), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_vc_i(wr_vc),
        .sched_stb_o(stb), .sched_vc_o(vc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic d);
        @(negedge clk);
        if (stb) begin
            stb_cnt++;
            last_vc = vc;
            if (stb_pos == -99) stb_pos = step_idx;
        end
        step_idx++;
        pace = c;
        done = d | (auto_done & stb);
    endtask

    task automatic period(input int h, input int l);
        stb_cnt = 0; stb_pos = -99; step_idx = -h;
        for (int i = 0; i < h; i++) step(1'b1, 1'b0);
        for (int i = 0; i < l; i++) step(1'b0, 1'b0);
    endtask

    task automatic write_entry(input int idx, input logic [VW-1:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx[$clog2(DEPTH)-1:0]; wr_vc = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; pace = 1'b0; done = 1'b0; wr_en = 1'b0;
        wr_idx = '0; wr_vc = '0; len = 5;
        repeat (4) @(negedge clk);
        chk(stb == 1'b0, "R8 strobe in reset", int'(stb), 0);
        chk(vc == '0, "R8 vc in reset", int'(vc), 0);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) write_entry(i, 16'hA000 + 16'(i));

        // table of pacing vectors
        for (int v = 0; v < NVEC; v++) begin
            period(VEC[v][0], VEC[v][1]);
            chk(stb_cnt == 1, "R1 R9 one strobe per fall", stb_cnt, 1);
            chk(stb_pos == 3, "R1 edge-to-strobe latency", stb_pos, 3);
            chk(last_vc == 16'hA000 + 16'(VEC[v][2]), "R3 R4 selected entry",
                int'(last_vc), int'(16'hA000 + 16'(VEC[v][2])));
        end

        // R7: rewritten entry
        write_entry(2, 16'hBEEF);
        period(3, 4);
        chk(last_vc == 16'hBEEF, "R7 rewritten entry", int'(last_vc), 'hBEEF);

        // R2 / R6: done withheld
        auto_done = 1'b0;
        period(3, 4);
        chk(stb_cnt == 1, "R2 first strobe", stb_cnt, 1);
        period(3, 4);
        chk(stb_cnt == 0, "R2 held while busy", stb_cnt, 0);
        period(3, 4);
        chk(stb_cnt == 0, "R6 extra edge held", stb_cnt, 0);
        stb_cnt = 0; stb_pos = -99;
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk(stb_cnt == 1, "R2 issue on done", stb_cnt, 1);
        chk(last_vc == 16'hA004, "R2 pending entry", int'(last_vc), 'hA004);
        step(1'b0, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
        chk(stb_cnt == 1, "R6 dropped edge not replayed", stb_cnt, 1);

        // R5: rewind while pending
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        period(3, 4);
        chk(last_vc == 16'hA000, "R5 setup entry", int'(last_vc), 'hA000);
        period(3, 4);
        period(10, 4);
        chk(stb_cnt == 0, "R6 no strobe while pending", stb_cnt, 0);
        stb_cnt = 0;
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk(stb_cnt == 1 && last_vc == 16'hA000, "R5 pending takes entry 0",
            int'(last_vc), 'hA000);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        auto_done = 1'b1;

        // R3: length of one
        len = 1;
        period(3, 4);
        chk(last_vc == 16'hA001, "R3 entry before wrap", int'(last_vc), 'hA001);
        period(3, 4);
        chk(last_vc == 16'hA000, "R3 length one wraps", int'(last_vc), 'hA000);
        period(3, 4);
        chk(last_vc == 16'hA000, "R3 length one holds", int'(last_vc), 'hA000);

        // R8: reset mid-run
        len = 5;
        period(3, 4);
        period(3, 4);
        chk(last_vc == 16'hA001, "R8 pre-reset entry", int'(last_vc), 'hA001);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(stb == 1'b0 && vc == '0, "R8 outputs cleared", int'(vc), 0);
        rst = 1'b0;
        period(3, 4);
        chk(stb_cnt == 1 && last_vc == 16'hA000, "R8 pointer back at top",
            int'(last_vc), 'hA000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule